// File: doc/BRIEF.md
# Display Shift Address Mapper

This block turns a visible character column (1 to 24) and a line select into a character RAM address for a text display. It keeps a single shift offset that shift-left and shift-right commands move. The mapper adds the offset to the column and wraps the sum within the length of the selected line. In one-line mode there is one line of 80 locations based at 00h. In two-line mode there are two lines of 40 locations, based at 00h and 40h. Both lines share the same offset, and each wraps on its own.

The address output is combinational from the column, line select, mode and offset register. A shift command changes the offset at the clock edge that samples it. A return-home command clears the offset. A change of the line mode also clears the offset, and the address output ignores the old offset in that same cycle.

Top module: `disp_shift_map`

## Requirements
- R1: After reset the offset is zero, and in one-line mode column c shows address c-1 (column 1 gives 00h, column 24 gives 17h).
- R2: In two-line mode with zero offset, line 1 (row=0) column c shows c-1 and line 2 (row=1) column c shows 40h+c-1, so column 24 on line 2 gives 57h.
- R3: A right-shift pulse (shift_right=1, shift_left=0) decrements the offset modulo the line length. In one-line mode, from zero, column 1 then shows 4Fh and column 2 shows 00h.
- R4: In two-line mode, one right shift from zero makes column 1 show 27h on line 1 and 67h on line 2, and column 2 show 00h and 40h.
- R5: A left-shift pulse (shift_left=1, shift_right=0) increments the offset modulo the line length. From zero, column 1 then shows 01h on line 1 and 41h on line 2.
- R6: The address is base + ((c-1+offset) mod length), where base is 00h for line 1 and 40h for line 2. Each line wraps within its own range, so after 17 left shifts in two-line mode column 24 shows 00h on line 1 and 40h on line 2.
- R7: The offset always lies below the current line length. 80 right shifts in one-line mode, or 40 left shifts in two-line mode, return it to zero.
- R8: A go_home pulse clears the offset at the next edge, and it takes priority over any shift sampled in the same cycle.
- R9: When two_line differs from its value at the previous edge, the address uses a zero offset in that same cycle, and the stored offset is zero from the next edge on.
- R10: A cycle with both shift_left and shift_right high leaves the offset unchanged.
- R11: In one-line mode the row input has no effect on the address.
- R12: The address follows col and row in the same cycle. A shift sampled at an edge changes the address only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| two_line | input | 1 | 1 = two lines of 40, 0 = one line of 80 |
| shift_left | input | 1 | Left-shift command, one cycle per shift |
| shift_right | input | 1 | Right-shift command, one cycle per shift |
| go_home | input | 1 | Clears the shift offset |
| col | input | 5 | Visible column, 1 to 24 |
| row | input | 1 | Line select: 0 = line 1, 1 = line 2 |
| addr | output | 7 | Character RAM address |

## Verification
The bench targets the wrap points. It checks column 1 after a right shift from zero, which must give 4Fh or 27h and not the result of a negative subtraction. It also checks column 24 when the sum lands exactly on the line length, where a design that wraps at 80 in two-line mode would show 28h instead of 00h. Full rotations in both directions confirm that the offset returns to zero and does not drift by one. The mode switch is checked in the very cycle of the change, which exposes a design that briefly uses a stale offset larger than 40. The bench also drives both shifts together and shift with home together, to catch wrong command priority.

// File: rtl/disp_shift_map.sv
module disp_shift_map #(
  parameter int VIS_COLS = 24,
  parameter int L1_LEN   = 80,
  parameter int L2_LEN   = 40,
  parameter int L2_BASE  = 64,
  parameter int AW       = 7,
  parameter int CW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          two_line,
  input  logic          shift_left,
  input  logic          shift_right,
  input  logic          go_home,
  input  logic [CW-1:0] col,
  input  logic          row,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] ofs, ofs_eff, len, pos_raw, pos;
  logic          mode_q, mode_chg;

  assign mode_chg = two_line != mode_q;
  assign len      = two_line ? AW'(L2_LEN) : AW'(L1_LEN);
  assign ofs_eff  = mode_chg ? '0 : ofs;
  assign pos_raw  = AW'(col) - AW'(1) + ofs_eff;
  assign pos      = (pos_raw >= len) ? pos_raw - len : pos_raw;
  assign addr     = (two_line && row) ? AW'(L2_BASE) + pos : pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs    <= '0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= two_line;
      if (go_home || mode_chg)
        ofs <= '0;
      else if (shift_left && !shift_right)
        ofs <= (ofs == len - AW'(1)) ? '0 : ofs + AW'(1);
      else if (shift_right && !shift_left)
        ofs <= (ofs == '0) ? len - AW'(1) : ofs - AW'(1);
    end
  end
endmodule

module disp_shift_map_chk #(
  parameter int VIS_COLS = 24,
  parameter int L1_LEN   = 80,
  parameter int L2_LEN   = 40,
  parameter int L2_BASE  = 64,
  parameter int AW       = 7,
  parameter int CW       = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          two_line,
  input logic          shift_left,
  input logic          shift_right,
  input logic          go_home,
  input logic [CW-1:0] col,
  input logic          row,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] ofs,
  input logic          mode_q
);
  logic col_ok, steady;
  assign col_ok = (col >= CW'(1)) && (col <= CW'(VIS_COLS));
  assign steady = (two_line == mode_q);

  AST_OFS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    steady |-> (ofs < (two_line ? AW'(L2_LEN) : AW'(L1_LEN)))); // R7
  AST_HOME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    go_home |=> (ofs == '0)); // R8
  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !steady |=> (ofs == '0)); // R9
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_left && shift_right && !go_home && steady) |=> $stable(ofs)); // R10
  AST_RIGHT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_right && !shift_left && !go_home && steady && ofs != '0)
      |=> (ofs == $past(ofs) - AW'(1))); // R3
  AST_LINE1_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (col_ok && !(two_line && row)) |->
      (addr < (two_line ? AW'(L2_LEN) : AW'(L1_LEN)))); // R6
  AST_LINE2_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (col_ok && two_line && row) |->
      (addr >= AW'(L2_BASE) && addr < AW'(L2_BASE + L2_LEN))); // R6
endmodule

bind disp_shift_map disp_shift_map_chk #(
  .VIS_COLS(VIS_COLS), .L1_LEN(L1_LEN), .L2_LEN(L2_LEN),
  .L2_BASE(L2_BASE), .AW(AW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .two_line(two_line), .shift_left(shift_left),
  .shift_right(shift_right), .go_home(go_home), .col(col), .row(row),
  .addr(addr), .ofs(ofs), .mode_q(mode_q)
);

// File: tb/disp_shift_map_test.sv
module disp_shift_map_test;
  logic clk = 0, rst_n = 0, two_line = 0, shift_left = 0, shift_right = 0, go_home = 0, row = 0;
  logic [4:0] col = 5'd1;
  logic [6:0] addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  disp_shift_map uut (.clk(clk), .rst_n(rst_n), .two_line(two_line), .shift_left(shift_left),
    .shift_right(shift_right), .go_home(go_home), .col(col), .row(row), .addr(addr));

  task automatic look(input string tag, input int c, input bit r, input int exp);
    col = 5'(c); row = r; #1;
    checks++;
    if (int'(addr) != exp) begin
      errors++;
      $display("FAIL %s col=%0d row=%0d got %h expected %h", tag, c, r, addr, exp);
    end
  endtask

  task automatic pulse(input bit l, input bit rt, input bit h, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); shift_left = l; shift_right = rt; go_home = h;
    end
    @(negedge clk); shift_left = 0; shift_right = 0; go_home = 0;
  endtask

  task automatic set_mode(input bit m);
    @(negedge clk); two_line = m;
    @(negedge clk);
  endtask

  task automatic t_reset;
    look("R1", 1, 0, 'h00);
    look("R1", 24, 0, 'h17);
    look("R12", 10, 0, 'h09);
  endtask

  task automatic t_two_plain;
    set_mode(1);
    look("R2", 1, 1, 'h40);
    look("R2", 24, 1, 'h57);
    look("R2", 5, 0, 'h04);
  endtask

  task automatic t_right_one;
    set_mode(0);
    @(negedge clk); shift_right = 1;
    look("R12", 1, 0, 'h00);
    @(negedge clk); shift_right = 0;
    look("R3", 1, 0, 'h4F);
    look("R3", 2, 0, 'h00);
  endtask

  task automatic t_right_two;
    set_mode(1);
    pulse(0, 1, 0, 1);
    look("R4", 1, 0, 'h27);
    look("R4", 1, 1, 'h67);
    look("R4", 2, 0, 'h00);
    look("R4", 2, 1, 'h40);
  endtask

  task automatic t_left;
    pulse(0, 0, 1, 1);
    pulse(1, 0, 0, 1);
    look("R5", 1, 0, 'h01);
    look("R5", 1, 1, 'h41);
  endtask

  task automatic t_wrap;
    pulse(0, 0, 1, 1);
    pulse(1, 0, 0, 17);
    look("R6", 24, 0, 'h00);
    look("R6", 24, 1, 'h40);
    look("R6", 23, 0, 'h27);
    look("R6", 23, 1, 'h67);
  endtask

  task automatic t_modulo;
    pulse(0, 0, 1, 1);
    pulse(1, 0, 0, 40);
    look("R7", 1, 1, 'h40);
    set_mode(0);
    pulse(0, 1, 0, 79);
    look("R7", 1, 0, 'h01);
    pulse(0, 1, 0, 1);
    look("R7", 1, 0, 'h00);
  endtask

  task automatic t_home;
    pulse(1, 0, 0, 5);
    look("R8", 1, 0, 'h05);
    pulse(1, 0, 1, 1);
    look("R8", 1, 0, 'h00);
  endtask

  task automatic t_mode;
    set_mode(1);
    pulse(1, 0, 0, 3);
    look("R9", 1, 0, 'h03);
    @(negedge clk); two_line = 0;
    look("R9", 1, 0, 'h00);
    @(negedge clk);
    look("R9", 1, 0, 'h00);
    look("R9", 24, 0, 'h17);
  endtask

  task automatic t_both;
    pulse(1, 0, 0, 2);
    pulse(1, 1, 0, 3);
    look("R10", 1, 0, 'h02);
  endtask

  task automatic t_row;
    look("R11", 3, 1, 'h04);
    look("R11", 3, 0, 'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_two_plain; t_right_one; t_right_two; t_left; t_wrap;
    t_modulo; t_home; t_mode; t_both; t_row;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule